// File: doc/BRIEF.md
# Byte FIFO and Transfer Counter Register Block

This block sits in the data path of a bus controller. It holds a 16-byte data FIFO and a 24-bit down-counter of bytes still to move. The host reaches both through byte-wide registers. Three registers load the counter one byte at a time. A single data register pushes bytes into the FIFO and pops them out. A read-only flags byte reports how many bytes the FIFO holds, and the same byte carries a 3-bit sequence step supplied from outside. A status byte shows when the counter has reached zero.

The bus side gives a one-cycle strobe for each byte it moves, and each strobe lowers the counter by one. A command register accepts a flush code that empties the FIFO at any moment. A sticky error output records a FIFO overrun or underrun until the next flush.

Register reads are combinational from `reg_addr`. A read of the data register removes the head byte on the clock edge that ends the access.

Top module: `xfr_fifo_regs`

## Requirements
- R1: After reset the counter is 0, the FIFO is empty, the error flag is 0, the flags byte reads {seq_step, 5'd0} and the status byte (address 4) reads 0x10.
- R2: A write to address 0, 1 or 14 loads bits 7:0, 15:8 or 23:16 of the counter and leaves the other bytes as they were. A read of the same address returns the current value of that byte.
- R3: Each cycle with `bus_byte` high and a nonzero counter lowers the counter by one. If a counter byte is written in the same cycle, the write takes effect and the decrement is skipped.
- R4: The counter holds at 0 and does not wrap. Status bit 4 (mask 0x10) is 1 exactly when the counter is 0, and all other status bits read 0.
- R5: A write to address 2 appends a byte to the FIFO. A read of address 2 returns the oldest byte combinationally and removes it at the clock edge, so bytes come out in the order they went in.
- R6: The flags byte at address 7 reads {seq_step[2:0], occupancy[4:0]} in the same cycle as the inputs, with no update delay.
- R7: A write to address 2 while the FIFO holds 16 bytes is dropped without changing its contents, and it sets the error flag.
- R8: A read of address 2 while the FIFO is empty returns 0x00 and sets the error flag.
- R9: Writing 0x01 to the command register (address 3) empties the FIFO and clears the error flag by the next cycle. Any other command value changes neither.
- R10: Once set, the error flag stays set until a flush.
- R11: Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 2) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| bus_byte | input | 1 | One byte moved on the bus side this cycle |
| seq_step | input | 3 | Current sequence step shown in the flags byte |
| fifo_err | output | 1 | Sticky FIFO overrun or underrun flag |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, because the block has one access port and a single operation per cycle. Under that assumption, a push and a pop never meet in one cycle, and a flush never coincides with a FIFO access. The stimulus issues exactly one register operation per task call and holds both strobes low between calls. It drives `bus_byte` independently of the register operations, which lets the load-beats-decrement case arise on purpose.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int unsigned CNT_W   = 24;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned LANES   = CNT_W / BYTE_W;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_MID = 4'd1;
  localparam logic [ADDR_W-1:0] A_DATA    = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd14;

  localparam logic [BYTE_W-1:0] CMD_FLUSH = 8'h01;
  localparam int unsigned STAT_TC_BIT = 4;

  // Saturating one-step decrement of the transfer count.
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  // Flags byte: step in the top three bits, occupancy in the low five.
  function automatic logic [BYTE_W-1:0] flags_pack(input logic [2:0] step,
                                                   input logic [4:0] occ);
    return {step, occ};
  endfunction
endpackage

// File: rtl/xfr_count.sv
module xfr_count
  import xfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      load_en,
  input  logic [BYTE_W-1:0]     load_byte,
  input  logic                  dec,
  output logic [CNT_W-1:0]      cnt,
  output logic                  zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (|load_en) begin
      for (int i = 0; i < int'(LANES); i++)
        if (load_en[i]) cnt_d[i*BYTE_W +: BYTE_W] = load_byte;
    end else if (dec) begin
      cnt_d = cnt_dec(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/xfr_byte_fifo.sv
module xfr_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      if (push && !pop)      lvl <= lvl + LW'(1);
      else if (pop && !push) lvl <= lvl - LW'(1);
    end

  always_ff @(posedge clk)
    if (push && !flush) mem[wp] <= wdata;

  assign empty = (lvl == '0);
  assign full  = (lvl == LW'(DEPTH));
  assign level = lvl;
  assign head  = empty ? '0 : mem[rp];
endmodule

// File: rtl/xfr_fifo_regs.sv
module xfr_fifo_regs
  import xfr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              bus_byte,
  input  logic [2:0]        seq_step,
  output logic              fifo_err
);
  // Named internal events, observed by the bound checker.
  logic             push_req, push_ok, push_drop;
  logic             pop_req, pop_ok, pop_empty;
  logic             flush, cnt_load;
  logic [LANES-1:0] load_en;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic [BYTE_W-1:0] head;
  logic [LW-1:0]    level;
  logic             full, empty;
  logic             err_q;

  assign push_req  = reg_wr && (reg_addr == A_DATA);
  assign pop_req   = reg_rd && (reg_addr == A_DATA);
  assign push_ok   = push_req && !full;
  assign push_drop = push_req && full;
  assign pop_ok    = pop_req && !empty;
  assign pop_empty = pop_req && empty;
  assign flush     = reg_wr && (reg_addr == A_CMD) && (reg_wdata == CMD_FLUSH);

  assign load_en[0] = reg_wr && (reg_addr == A_CNT_LO);
  assign load_en[1] = reg_wr && (reg_addr == A_CNT_MID);
  assign load_en[2] = reg_wr && (reg_addr == A_CNT_HI);
  assign cnt_load   = |load_en;

  xfr_count u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_byte (reg_wdata),
    .dec       (bus_byte),
    .cnt       (cnt),
    .zero      (cnt_zero)
  );

  xfr_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .pop   (pop_ok),
    .flush (flush),
    .wdata (reg_wdata),
    .head  (head),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      err_q <= 1'b0;
    else if (flush)                  err_q <= 1'b0;
    else if (push_drop || pop_empty) err_q <= 1'b1;

  assign fifo_err = err_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT_LO:  reg_rdata = cnt[7:0];
      A_CNT_MID: reg_rdata = cnt[15:8];
      A_CNT_HI:  reg_rdata = cnt[23:16];
      A_DATA:    reg_rdata = head;
      A_STAT:    reg_rdata[STAT_TC_BIT] = cnt_zero;
      A_FLAGS:   reg_rdata = flags_pack(seq_step, 5'(level));
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xfr_fifo_regs_chk.sv
module xfr_fifo_regs_chk
  import xfr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_byte,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt,
  input logic [LW-1:0]    level,
  input logic             push_req,
  input logic             push_ok,
  input logic             pop_req,
  input logic             flush,
  input logic             err
);
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && bus_byte && !cnt_load |=> cnt == $past(cnt) - CW1);
  localparam logic [CNT_W-1:0] CW1 = CNT_W'(1);

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && bus_byte && !cnt_load |=> cnt == '0);

  a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_req && !flush |=> level == $past(level) + LW'(1));

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH)) && push_req && !pop_req |=> (level == LW'(DEPTH)) && err);

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) && pop_req && !flush |=> err);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && !err);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !flush |=> err);
endmodule

bind xfr_fifo_regs xfr_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_byte (bus_byte),
  .cnt_load (cnt_load),
  .cnt      (cnt),
  .level    (level),
  .push_req (push_req),
  .push_ok  (push_ok),
  .pop_req  (pop_req),
  .flush    (flush),
  .err      (fifo_err)
);

// File: tb/sim_xfr_fifo_regs.sv
`timescale 1ns/1ps
module sim_xfr_fifo_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, bus_byte = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [2:0] seq_step = 3'd0;
  logic [7:0] reg_rdata;
  logic       fifo_err;

  int n_chk = 0, n_fail = 0;

  // Reference model
  logic [7:0] q[$];
  int unsigned m_cnt = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  xfr_fifo_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_byte(bus_byte), .seq_step(seq_step), .fifo_err(fifo_err)
  );

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:  return m_cnt[7:0];
      4'd1:  return m_cnt[15:8];
      4'd14: return m_cnt[23:16];
      4'd2:  return (q.size() != 0) ? q[0] : 8'h00;
      4'd4:  return (m_cnt == 0) ? 8'h10 : 8'h00;
      4'd7:  return {seq_step, 5'(q.size())};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // One register operation per clock; outputs compared before the edge.
  task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                    input logic [7:0] d, input bit bb, input string tag);
    bit loaded;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; bus_byte = bb;
    #2;
    check8(tag, reg_rdata, exp_rd(a));
    check8({tag, " err"}, {7'd0, fifo_err}, {7'd0, m_err});
    @(posedge clk);
    loaded = 0;
    if (wr) begin
      case (a)
        4'd0:  begin m_cnt[7:0]   = d; loaded = 1; end
        4'd1:  begin m_cnt[15:8]  = d; loaded = 1; end
        4'd14: begin m_cnt[23:16] = d; loaded = 1; end
        4'd2:  if (q.size() < 16) q.push_back(d); else m_err = 1;
        4'd3:  if (d == 8'h01) begin q.delete(); m_err = 0; end
        default: ;
      endcase
    end
    if (rd && a == 4'd2) begin
      if (q.size() != 0) void'(q.pop_front()); else m_err = 1;
    end
    if (!loaded && bb && m_cnt != 0) m_cnt--;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; bus_byte = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    op(0,0,4'd4,0,0,"R1 status");
    op(0,0,4'd7,0,0,"R1 flags");
    op(0,0,4'd0,0,0,"R1 cnt lo");
    // R2 byte loads and readback
    op(1,0,4'd0,8'hA5,0,"R2 wr lo");
    op(1,0,4'd1,8'h12,0,"R2 wr mid");
    op(1,0,4'd14,8'h34,0,"R2 wr hi");
    op(0,0,4'd0,0,0,"R2 rd lo");
    op(0,0,4'd1,0,0,"R2 rd mid");
    op(0,0,4'd14,0,0,"R2 rd hi");
    // R3 decrement, borrow across bytes
    op(1,0,4'd0,8'h01,0,"R3 set");
    op(0,0,4'd0,0,1,"R3 dec");
    op(0,0,4'd0,0,1,"R3 borrow");
    op(0,0,4'd1,0,0,"R3 mid after borrow");
    // R3 load beats decrement
    op(1,0,4'd1,8'h00,1,"R3 load+dec");
    op(1,0,4'd14,8'h00,0,"R3 clr hi");
    op(1,0,4'd0,8'h02,1,"R3 load lo+dec");
    op(0,0,4'd0,0,0,"R3 load wins");
    // R4 saturate at zero, status bit
    op(0,0,4'd4,0,1,"R4 status nz");
    op(0,0,4'd4,0,1,"R4 to zero");
    for (int i = 0; i < 3; i++) op(0,0,4'd0,0,1,"R4 hold zero");
    op(0,0,4'd4,0,0,"R4 status zero");
    op(0,0,4'd14,0,0,"R4 no wrap");
    // R5/R6 FIFO order and flags
    seq_step = 3'd5;
    for (int i = 0; i < 5; i++) op(1,0,4'd2,8'h30 + 8'(i),0,"R5 push");
    op(0,0,4'd7,0,0,"R6 flags");
    seq_step = 3'd2;
    op(0,0,4'd7,0,0,"R6 step change");
    for (int i = 0; i < 5; i++) op(0,1,4'd2,0,0,"R5 pop order");
    op(0,0,4'd7,0,0,"R6 empty flags");
    // R8 underrun
    op(0,1,4'd2,0,0,"R8 empty read");
    op(0,0,4'd2,0,0,"R10 err held");
    // R9 non-flush command, then flush
    op(1,0,4'd3,8'h02,0,"R9 other cmd");
    op(0,0,4'd7,0,0,"R10 still set");
    op(1,0,4'd3,8'h01,0,"R9 flush");
    op(0,0,4'd7,0,0,"R9 after flush");
    // R7 overrun
    for (int i = 0; i < 16; i++) op(1,0,4'd2,8'h80 + 8'(i),0,"R7 fill");
    op(0,0,4'd7,0,0,"R7 full flags");
    op(1,0,4'd2,8'hEE,0,"R7 overrun");
    op(0,0,4'd7,0,0,"R7 level kept");
    for (int i = 0; i < 16; i++) op(0,1,4'd2,0,0,"R7 contents");
    op(0,0,4'd7,0,0,"R10 err kept");
    // R9 flush a partly filled FIFO
    op(1,0,4'd2,8'h55,0,"R9 push");
    op(1,0,4'd2,8'h66,0,"R9 push");
    op(1,0,4'd3,8'h01,0,"R9 flush2");
    op(0,0,4'd2,0,0,"R9 empty data");
    // R11 unmapped addresses
    op(0,0,4'd9,0,0,"R11 unmapped");
    op(0,0,4'd15,0,0,"R11 unmapped");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule